// File: doc/BRIEF.md
# Character LCD Sequencing Controller

This block sits between user logic and a parallel character LCD module with an 8-bit data bus. After reset it holds every LCD line low while the module's supply settles. It then sends a fixed start-up command sequence on its own, waiting after each command long enough for the module to finish it. Once that sequence is done it accepts one command or character at a time from user logic.

User logic watches `busy`. While `busy` is low, a one-cycle `start` pulse hands over a 10-bit word. That word holds the register-select level, the read/write level and the data byte. The controller drives these onto the LCD lines and produces a single enable strobe with setup and hold margins around it. It keeps the lines steady for a fixed transfer time and then returns to the idle, ready state. Every delay is a whole number of microseconds converted to clock cycles from the `CLK_HZ` parameter.

Top module: `char_lcd_ctrl`

## Requirements
- R1: While `rst_n` is low, `busy` is 1 and `lcd_e`, `lcd_rs`, `lcd_rw` and `lcd_data` are all 0. Reset is asynchronous.
- R2: After reset is released, the LCD lines stay at 0 for PWRUP_US microseconds. The first start-up command then begins, and its enable rises one microsecond after that.
- R3: The start-up sequence sends four commands, in this order, with `lcd_rs` = 0 and `lcd_rw` = 0: 0x38 (8-bit bus, two lines), 0x0C (display on, cursor and blink off), 0x01 (clear) and 0x06 (increment address, no display shift).
- R4: Each start-up command occupies CMD_WAIT_US microseconds from its start to the start of the next one. The clear command is the exception and occupies CLEAR_WAIT_US.
- R5: `busy` stays 1 from reset until the end of the start-up sequence. It falls exactly PWRUP_US + 3·CMD_WAIT_US + CLEAR_WAIT_US microseconds after reset release.
- R6: When `start` is 1 at a clock edge while `busy` is 0, the controller captures `cmd_word`. On the LCD lines, bit 9 becomes `lcd_rs`, bit 8 becomes `lcd_rw` and bits 7:0 become `lcd_data`. The lines hold these values for SEND_US microseconds, with `busy` at 1 throughout, and then `busy` returns to 0.
- R7: Within every command and every transfer, `lcd_e` goes high one microsecond after the lines are set and stays high for exactly one microsecond. The lines keep their values across both edges of `lcd_e`.
- R8: `start` and `cmd_word` have no effect while `busy` is 1. This holds both during start-up and during a transfer.
- R9: Pulling `rst_n` low at any point, including in the middle of a transfer, restarts the whole power-up wait and start-up sequence.
- R10: While `busy` is 0, `lcd_e` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to send `cmd_word`; taken only while `busy` is 0 |
| cmd_word | input | 10 | Bit 9 register select, bit 8 read/write, bits 7:0 data |
| busy | output | 1 | High during power-up wait, start-up sequence and each transfer |
| lcd_rs | output | 1 | LCD register-select line |
| lcd_rw | output | 1 | LCD read/write line |
| lcd_e | output | 1 | LCD enable strobe |
| lcd_data | output | 8 | LCD data bus |

## Verification
The bench builds the controller with CLK_HZ = 10 MHz, which gives ten cycles per microsecond. It shortens the waits to a 20 µs power-up, 10 µs per ordinary command, 100 µs for clear and 8 µs per transfer. With these values the whole start-up sequence takes 1,500 cycles. That makes it affordable to run start-up twice, to see every enable edge, to measure exact intervals between commands, and to reset in the middle of a transfer and watch the sequence start again.

// File: rtl/lcd_ctrl_pkg.sv
package lcd_ctrl_pkg;

    localparam int INIT_STEPS = 4;
    localparam int IDX_W      = $clog2(INIT_STEPS);

    typedef enum logic [1:0] {
        ST_PWR   = 2'd0,
        ST_INIT  = 2'd1,
        ST_READY = 2'd2,
        ST_SEND  = 2'd3
    } lcd_state_e;

    // Field order matters: rs takes bit 9 and rw takes bit 8 of the user word.
    typedef struct packed {
        logic       rs;
        logic       rw;
        logic [7:0] data;
    } lcd_word_t;

    // Start-up command bytes. The position in the sequence is part of the behaviour.
    function automatic logic [7:0] init_code(input logic [IDX_W-1:0] idx);
        logic [7:0] c;
        case (idx)
            IDX_W'(0): c = 8'h38;
            IDX_W'(1): c = 8'h0C;
            IDX_W'(2): c = 8'h01;
            default:   c = 8'h06;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/lcd_init_table.sv
module lcd_init_table
    import lcd_ctrl_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output lcd_word_t        word,
    output logic             long_wait,
    output logic             last
);

    always_comb begin
        word.rs   = 1'b0;
        word.rw   = 1'b0;
        word.data = init_code(idx);
        // Only the clear command needs the long completion wait.
        long_wait = (word.data == 8'h01);
        last      = (idx == IDX_W'(INIT_STEPS - 1));
    end

endmodule

// File: rtl/lcd_step_timer.sv
module lcd_step_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic [CW-1:0] count_d,
    output logic          at_end
);

    logic [CW-1:0] count_q;

    always_comb begin
        at_end  = (count_q == limit - CW'(1));
        count_d = restart ? '0 : count_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    // R4: the phase counter never runs past the window of the current step
    a_r4_count_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        count_q < limit);

endmodule

// File: rtl/lcd_pin_driver.sv
module lcd_pin_driver
    import lcd_ctrl_pkg::*;
#(
    parameter int CW     = 8,
    parameter int SU_CYC = 1,
    parameter int PW_CYC = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_d,
    input  lcd_word_t     word_d,
    input  logic [CW-1:0] count_d,
    output logic          lcd_rs,
    output logic          lcd_rw,
    output logic          lcd_e,
    output logic [7:0]    lcd_data
);

    localparam logic [CW-1:0] RISE_AT = CW'(SU_CYC);
    localparam logic [CW-1:0] FALL_AT = CW'(SU_CYC + PW_CYC);

    typedef struct packed {
        logic       rs;
        logic       rw;
        logic       e;
        logic [7:0] data;
    } pins_t;

    pins_t pins_d, pins_q;

    always_comb begin
        pins_d = '0;
        if (active_d) begin
            pins_d.rs   = word_d.rs;
            pins_d.rw   = word_d.rw;
            pins_d.data = word_d.data;
            pins_d.e    = (count_d >= RISE_AT) && (count_d < FALL_AT);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pins_q <= '0;
        else        pins_q <= pins_d;
    end

    assign lcd_rs   = pins_q.rs;
    assign lcd_rw   = pins_q.rw;
    assign lcd_e    = pins_q.e;
    assign lcd_data = pins_q.data;

    // R7: lines already settled when the strobe rises
    a_r7_setup_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lcd_e) |-> $stable({lcd_rs, lcd_rw, lcd_data}));
    // R7: lines still held when the strobe falls
    a_r7_hold_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lcd_e) |-> $stable({lcd_rs, lcd_rw, lcd_data}));

endmodule

// File: rtl/char_lcd_ctrl.sv
module char_lcd_ctrl
    import lcd_ctrl_pkg::*;
#(
    parameter int CLK_HZ        = 50_000_000,
    parameter int PWRUP_US      = 50_000,
    parameter int CMD_WAIT_US   = 50,
    parameter int CLEAR_WAIT_US = 2_000,
    parameter int SEND_US       = 50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [9:0] cmd_word,
    output logic       busy,
    output logic       lcd_rs,
    output logic       lcd_rw,
    output logic       lcd_e,
    output logic [7:0] lcd_data
);

    localparam int US_CYC  = (CLK_HZ >= 1_000_000) ? CLK_HZ / 1_000_000 : 1;
    localparam int PWR_CYC = PWRUP_US * US_CYC;
    localparam int CMD_CYC = CMD_WAIT_US * US_CYC;
    localparam int CLR_CYC = CLEAR_WAIT_US * US_CYC;
    localparam int SND_CYC = SEND_US * US_CYC;
    localparam int MAX_AB  = (PWR_CYC > CLR_CYC) ? PWR_CYC : CLR_CYC;
    localparam int MAX_CD  = (CMD_CYC > SND_CYC) ? CMD_CYC : SND_CYC;
    localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW      = $clog2(MAX_CYC + 1);

    localparam logic [CW-1:0] PWR_L = CW'(PWR_CYC);
    localparam logic [CW-1:0] CMD_L = CW'(CMD_CYC);
    localparam logic [CW-1:0] CLR_L = CW'(CLR_CYC);
    localparam logic [CW-1:0] SND_L = CW'(SND_CYC);
    localparam logic [CW-1:0] ONE_L = CW'(1);

    typedef struct packed {
        lcd_state_e       st;
        logic [IDX_W-1:0] idx;
        lcd_word_t        word;
    } fsm_t;

    fsm_t            r_q, r_d;
    lcd_word_t       tab_word;
    logic            tab_long, tab_last;
    logic            restart, at_end, active_d;
    logic [CW-1:0]   limit, count_d;
    lcd_word_t       bus_d;

    lcd_init_table u_table (
        .idx       (r_q.idx),
        .word      (tab_word),
        .long_wait (tab_long),
        .last      (tab_last)
    );

    lcd_step_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit),
        .count_d (count_d),
        .at_end  (at_end)
    );

    always_comb begin
        r_d     = r_q;
        restart = 1'b0;
        limit   = ONE_L;
        case (r_q.st)
            ST_PWR: begin
                limit = PWR_L;
                if (at_end) begin
                    r_d.st  = ST_INIT;
                    r_d.idx = '0;
                    restart = 1'b1;
                end
            end
            ST_INIT: begin
                limit = tab_long ? CLR_L : CMD_L;
                if (at_end) begin
                    restart = 1'b1;
                    if (tab_last) r_d.st  = ST_READY;
                    else          r_d.idx = r_q.idx + IDX_W'(1);
                end
            end
            ST_READY: begin
                limit   = ONE_L;
                restart = 1'b1;
                if (start) begin
                    r_d.st   = ST_SEND;
                    r_d.word = lcd_word_t'(cmd_word);
                end
            end
            default: begin
                limit = SND_L;
                if (at_end) begin
                    restart = 1'b1;
                    r_d.st  = ST_READY;
                end
            end
        endcase

        active_d = (r_d.st == ST_INIT) || (r_d.st == ST_SEND);
        if (r_d.st == ST_INIT) begin
            bus_d.rs   = 1'b0;
            bus_d.rw   = 1'b0;
            bus_d.data = init_code(r_d.idx);
        end else begin
            bus_d = r_d.word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_PWR, idx: '0, word: '0};
        else        r_q <= r_d;
    end

    assign busy = (r_q.st != ST_READY);

    lcd_pin_driver #(
        .CW     (CW),
        .SU_CYC (US_CYC),
        .PW_CYC (US_CYC)
    ) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_d (active_d),
        .word_d   (bus_d),
        .count_d  (count_d),
        .lcd_rs   (lcd_rs),
        .lcd_rw   (lcd_rw),
        .lcd_e    (lcd_e),
        .lcd_data (lcd_data)
    );

    // R10: no strobe while idle
    a_r10_strobe_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        lcd_e |-> busy);
    // R2: lines quiet during the power-up wait
    a_r2_quiet_in_powerup: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_PWR) |-> (!lcd_e && lcd_data == 8'h00 && !lcd_rs && !lcd_rw));
    // R6: captured word held on the lines for the whole transfer
    a_r6_send_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SEND && $past(r_q.st) == ST_SEND) |-> $stable({lcd_rs, lcd_rw, lcd_data}));
    // R8: a transfer can only be entered from the ready state
    a_r8_send_only_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SEND) |-> ($past(r_q.st) == ST_SEND || $past(r_q.st) == ST_READY));

endmodule

// File: tb/sim_char_lcd_ctrl.sv
`timescale 1ns/1ps
module sim_char_lcd_ctrl;

    localparam int US  = 10;
    localparam int PWR = 20 * US;
    localparam int CMD = 10 * US;
    localparam int CLR = 100 * US;
    localparam int SND = 8 * US;
    localparam int INIT_END = PWR + 3 * CMD + CLR;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [9:0] cmd_word = '0;
    logic       busy, lcd_rs, lcd_rw, lcd_e;
    logic [7:0] lcd_data;

    always #2 clk = ~clk;

    char_lcd_ctrl #(
        .CLK_HZ        (10_000_000),
        .PWRUP_US      (20),
        .CMD_WAIT_US   (10),
        .CLEAR_WAIT_US (100),
        .SEND_US       (8)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .start (start), .cmd_word (cmd_word),
        .busy (busy), .lcd_rs (lcd_rs), .lcd_rw (lcd_rw), .lcd_e (lcd_e),
        .lcd_data (lcd_data)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    function automatic logic [7:0] code_of(input int i);
        case (i)
            0: return 8'h38;
            1: return 8'h0C;
            2: return 8'h01;
            default: return 8'h06;
        endcase
    endfunction

    // Behavioural reference: phase 0 wait, 1 start-up, 2 idle, 3 transfer
    int         m_ph, m_cnt, m_idx, m_lim, cyc;
    logic [9:0] m_word;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_idx = 0; m_word = '0; cyc = 0;
        end else begin
            cyc++;
            case (m_ph)
                0: if (m_cnt == PWR - 1) begin m_ph = 1; m_cnt = 0; m_idx = 0; end
                   else m_cnt++;
                1: begin
                    m_lim = (m_idx == 2) ? CLR : CMD;
                    if (m_cnt == m_lim - 1) begin
                        m_cnt = 0;
                        if (m_idx == 3) m_ph = 2; else m_idx++;
                    end else m_cnt++;
                end
                2: if (start) begin m_ph = 3; m_cnt = 0; m_word = cmd_word; end
                default: if (m_cnt == SND - 1) begin m_ph = 2; m_cnt = 0; end
                         else m_cnt++;
            endcase
        end
    end

    // Per-cycle comparison and edge log
    int         rise_cyc[16], fall_cyc[16];
    logic [9:0] rise_bus[16];
    int         n_rise, n_fall, busy_fall, idle_e;
    logic       e_prev;

    always @(negedge clk) begin
        logic       act;
        logic       exp_e;
        logic [9:0] exp_bus;
        logic [9:0] bus;
        act     = (m_ph == 1) || (m_ph == 3);
        exp_e   = act && (m_cnt >= US) && (m_cnt < 2 * US);
        exp_bus = (m_ph == 1) ? {2'b00, code_of(m_idx)} : (m_ph == 3) ? m_word : 10'h000;
        bus     = {lcd_rs, lcd_rw, lcd_data};
        check(busy == (m_ph != 2), "R5 busy per cycle", int'(busy), int'(m_ph != 2));
        check(lcd_e == exp_e, "R7 enable per cycle", int'(lcd_e), int'(exp_e));
        check(bus == exp_bus, (m_ph == 3) ? "R6 lines per cycle" : "R3 lines per cycle",
              int'(bus), int'(exp_bus));
        if (!rst_n) begin
            n_rise = 0; n_fall = 0; busy_fall = -1;
        end else begin
            if (lcd_e && !e_prev && n_rise < 16) begin
                rise_cyc[n_rise] = cyc; rise_bus[n_rise] = bus; n_rise++;
            end
            if (!lcd_e && e_prev && n_fall < 16) begin
                fall_cyc[n_fall] = cyc; n_fall++;
            end
            if (!busy && busy_fall < 0) busy_fall = cyc;
            if (!busy && lcd_e) idle_e++;
        end
        e_prev = lcd_e;
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd == 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        idle_e = 0; e_prev = 1'b0; n_rise = 0; n_fall = 0; busy_fall = -1;
        step(2);
        check(busy && !lcd_e && {lcd_rs, lcd_rw, lcd_data} == 10'h000, "R1 reset state",
              int'({busy, lcd_e, lcd_rs, lcd_rw, lcd_data}), 12'h800);
        rst_n = 1'b1;
        step(INIT_END + 4);

        check(n_rise == 4, "R3 start-up strobe count", n_rise, 4);
        for (int k = 0; k < 4; k++)
            check(rise_bus[k] == {2'b00, code_of(k)}, "R3 start-up command order",
                  int'(rise_bus[k]), int'({2'b00, code_of(k)}));
        check(rise_cyc[0] == PWR + US, "R2 power-up wait", rise_cyc[0], PWR + US);
        check(rise_cyc[1] - rise_cyc[0] == CMD, "R4 short command wait",
              rise_cyc[1] - rise_cyc[0], CMD);
        check(rise_cyc[3] - rise_cyc[2] == CLR, "R4 clear wait",
              rise_cyc[3] - rise_cyc[2], CLR);
        check(busy_fall == INIT_END, "R5 busy release time", busy_fall, INIT_END);
        check(fall_cyc[0] - rise_cyc[0] == US, "R7 strobe width",
              fall_cyc[0] - rise_cyc[0], US);

        step(40);
        check(idle_e == 0 && !lcd_e, "R10 idle strobe low", idle_e, 0);

        // Transfer with rs=1, rw=0, data 0x41; start and word wiggled mid-transfer
        start = 1'b1; cmd_word = 10'h241;
        step(1);
        start = 1'b0; cmd_word = 10'h3FF;
        step(20);
        start = 1'b1; cmd_word = 10'h155;
        step(1);
        start = 1'b0;
        step(SND + 10);
        check(n_rise == 5, "R8 start ignored while busy", n_rise, 5);
        check(rise_bus[4] == 10'h241, "R6 captured word fields", int'(rise_bus[4]), 10'h241);
        check(fall_cyc[4] - rise_cyc[4] == US, "R7 transfer strobe width",
              fall_cyc[4] - rise_cyc[4], US);
        check(!busy, "R6 busy released after transfer", int'(busy), 0);

        // Transfer with rw=1, rs=0
        start = 1'b1; cmd_word = 10'h1AA;
        step(1);
        start = 1'b0;
        step(SND + 10);
        check(n_rise == 6 && rise_bus[5] == 10'h1AA, "R6 rw field", int'(rise_bus[5]), 10'h1AA);

        // Reset in the middle of a transfer, start held high through start-up
        start = 1'b1; cmd_word = 10'h230;
        step(1);
        step(30);
        rst_n = 1'b0;
        step(1);
        check(busy && !lcd_e && {lcd_rs, lcd_rw, lcd_data} == 10'h000, "R9 reset mid-transfer",
              int'({busy, lcd_e, lcd_rs, lcd_rw, lcd_data}), 12'h800);
        rst_n = 1'b1;
        step(INIT_END - 2);
        check(n_rise == 4 && rise_bus[0] == 10'h038, "R8 start held during start-up ignored",
              n_rise, 4);
        check(rise_cyc[0] == PWR + US, "R9 power-up wait repeated", rise_cyc[0], PWR + US);
        step(SND);
        check(busy_fall == INIT_END, "R9 start-up repeated in full", busy_fall, INIT_END);
        check(n_rise == 5 && rise_bus[4] == 10'h230, "R6 immediate send after start-up",
              int'(rise_bus[4]), 10'h230);
        start = 1'b0;
        step(SND + 10);
        check(idle_e == 0, "R10 no idle strobe over run", idle_e, 0);
        finish_run();
    end

endmodule